// File: doc/BRIEF.md
# Selectable Odd/Even Clock Divider with 50% Duty

This block divides its input clock by 3, 4, 5 or 6. A 2-bit select code chooses the ratio. The output duty cycle is exactly one half for every ratio, including the odd ones.

For odd ratios, a waveform launched on the rising edge is combined with a copy of it retimed on the falling edge. The copy lags by half an input cycle, so the high time stretches to N/2 input cycles. For even ratios, only the rising-edge waveform is used.

The block drives several true/complement output pairs from one divided clock, so all pairs are edge-aligned. An active-high master reset clears the divider at once and holds every true output low and every complement output high. Its release is synchronised to the input clock, so the first output edge after reset lands on a fixed input edge.

A new select code is sampled only when the period counter wraps. A code change part-way through a period therefore finishes the running period at the old ratio, and no short pulse is produced.

Top module: `dual_edge_div`

## Requirements
- R1: Select code 00 gives a period of 3 input cycles, 01 gives 4, 10 gives 5 and 11 gives 6. The true output rises once per period, on a rising input edge.
- R2: For the even ratios 4 and 6, the true output is high for exactly N/2 input cycles of each N-cycle period, and it falls on a rising input edge.
- R3: While the master reset is high, every true output is low and every complement output is high. This takes effect without waiting for an input clock edge.
- R4: After the master reset falls between two rising input edges, the true outputs stay low through the first two rising edges and rise on the third.
- R5: Each complement output is always the inverse of its true output.
- R6: All true outputs carry the same waveform, aligned to one another.
- R7: The select code is applied only at the rising edge that starts a new period. A code change at any time, including the cycle just before the wrap, leaves the running period at the old ratio. The next period uses the new code.
- R8: For the odd ratios 3 and 5, the true output is high for N/2 input cycles (N half-cycles) and falls on a falling input edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| mreset | input | 1 | Master reset, active high; asserted asynchronously, released synchronously |
| div_sel | input | 2 | Ratio select code: 00=3, 01=4, 10=5, 11=6 |
| clk_out | output | NUM_OUT | True divided clock outputs |
| clk_out_n | output | NUM_OUT | Complement divided clock outputs |

## Verification
The risky overlap is a select-code change and a period wrap falling in the same input cycle. In that cycle the counter reloads and the ratio register captures the code. The bench sweeps every ordered pair of codes. For each pair it places the change at a different cycle of the running period, including the last one before the wrap.

The bench keeps a half-cycle-resolution model of the output, in which each period takes the code present at its starting edge. It compares both outputs against that model at every half cycle. A ratio applied one period early or late, or a runt pulse, therefore shows up as a mismatch.

// File: rtl/dual_edge_div_pkg.sv
package dual_edge_div_pkg;
  localparam int SEL_W = 2;
  localparam int CNT_W = 3;
  localparam int MIN_RATIO = 3;

  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;

  // The code maps linearly: ratio = code + 3.
  function automatic cnt_t ratio_of(input sel_t code);
    return CNT_W'(code) + CNT_W'(MIN_RATIO);
  endfunction
endpackage

// File: rtl/dual_edge_div_rst_sync.sv
module dual_edge_div_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic mreset,
  output logic rst_n_o
);
  logic [SYNC_STAGES-1:0] sync_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or posedge mreset) begin
        if (mreset) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or posedge mreset) begin
        if (mreset) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_o = sync_q[SYNC_STAGES-1];
endmodule

// File: rtl/dual_edge_div_counter.sv
module dual_edge_div_counter
  import dual_edge_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sel_t sel,
  output cnt_t cnt_nxt_o,
  output cnt_t ratio_nxt_o,
  output logic wrap_o
);
  cnt_t cnt_q, cnt_d;
  cnt_t ratio_q, ratio_d;
  logic wrap;

  always_comb begin
    wrap    = (cnt_q == ratio_q - CNT_W'(1));
    cnt_d   = wrap ? '0 : cnt_q + CNT_W'(1);
    ratio_d = ratio_of(sel);
  end

  // The reset state is a wrap, so the first active edge loads the code.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_W'(MIN_RATIO - 1);
      ratio_q <= CNT_W'(MIN_RATIO);
    end else begin
      cnt_q <= cnt_d;
      if (wrap) ratio_q <= ratio_d;
    end
  end

  assign cnt_nxt_o   = cnt_d;
  assign ratio_nxt_o = wrap ? ratio_d : ratio_q;
  assign wrap_o      = wrap;

  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < ratio_q);

  p_ratio_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(ratio_q));
endmodule

// File: rtl/dual_edge_div_shaper.sv
module dual_edge_div_shaper
  import dual_edge_div_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cnt_t cnt_nxt,
  input  cnt_t ratio_nxt,
  output logic div_o
);
  logic pos_q, pos_d;
  logic odd_q, odd_d;
  logic neg_q;

  always_comb begin
    pos_d = (cnt_nxt < (ratio_nxt >> 1));
    odd_d = ratio_nxt[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= 1'b0;
      odd_q <= 1'b0;
    end else begin
      pos_q <= pos_d;
      odd_q <= odd_d;
    end
  end

  // Half-cycle retimed copy; stretches the high time on odd ratios.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) neg_q <= 1'b0;
    else        neg_q <= pos_q;
  end

  assign div_o = pos_q | (odd_q & neg_q);
endmodule

// File: rtl/dual_edge_div.sv
module dual_edge_div
  import dual_edge_div_pkg::*;
#(
  parameter int NUM_OUT     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               mreset,
  input  logic [SEL_W-1:0]   div_sel,
  output logic [NUM_OUT-1:0] clk_out,
  output logic [NUM_OUT-1:0] clk_out_n
);
  logic rst_n;
  cnt_t cnt_nxt;
  cnt_t ratio_nxt;
  logic wrap;
  logic div_clk;

  dual_edge_div_rst_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .mreset  (mreset),
    .rst_n_o (rst_n)
  );

  dual_edge_div_counter u_counter (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel         (div_sel),
    .cnt_nxt_o   (cnt_nxt),
    .ratio_nxt_o (ratio_nxt),
    .wrap_o      (wrap)
  );

  dual_edge_div_shaper u_shaper (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_nxt   (cnt_nxt),
    .ratio_nxt (ratio_nxt),
    .div_o     (div_clk)
  );

  generate
    for (genvar g = 0; g < NUM_OUT; g++) begin : g_pair
      assign clk_out[g]   = div_clk;
      assign clk_out_n[g] = ~div_clk;
    end
  endgenerate

  // The last cycle of every period is low; the first is high.
  p_tail_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> !clk_out[0]);

  p_head_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> clk_out[0]);
endmodule

// File: tb/dual_edge_div_bench.sv
`timescale 1ns/1ps
module dual_edge_div_bench;
  localparam int NUM_OUT = 2;

  logic clk;
  logic mreset;
  logic [1:0] sel;
  logic [NUM_OUT-1:0] clk_out;
  logic [NUM_OUT-1:0] clk_out_n;

  int vecs;
  int fails;
  int cur;
  int j;
  bit restart;
  bit chg_mode;

  dual_edge_div #(.NUM_OUT(NUM_OUT), .SYNC_STAGES(2)) u_dual_edge_div (
    .clk       (clk),
    .mreset    (mreset),
    .div_sel   (sel),
    .clk_out   (clk_out),
    .clk_out_n (clk_out_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic exp, input string tag);
    vecs++;
    if (clk_out[0] !== exp) begin
      fails++;
      $display("FAIL %s: clk_out[0]=%b expected %b at %0t", tag, clk_out[0], exp, $time);
    end
    vecs++;
    if (clk_out !== {NUM_OUT{clk_out[0]}}) begin
      fails++;
      $display("FAIL R6: clk_out=%b expected %b", clk_out, {NUM_OUT{clk_out[0]}});
    end
    vecs++;
    if (clk_out_n !== ~clk_out) begin
      fails++;
      $display("FAIL R5: clk_out_n=%b expected %b", clk_out_n, ~clk_out);
    end
  endtask

  // One full input cycle, checked at both half-cycle positions.
  task automatic step();
    logic [1:0] snap;
    string tag;
    snap = sel;
    @(posedge clk);
    if (restart || j == 2 * cur) begin
      cur = int'(snap) + 3;
      j = 0;
      restart = 0;
    end
    tag = chg_mode ? "R7" : ((cur % 2) == 1 ? "R1 R8" : "R1 R2");
    #1.25;
    chk(j < cur, tag);
    j++;
    @(negedge clk);
    #1.25;
    chk(j < cur, tag);
    j++;
  endtask

  // Called at posedge+1.25; releases reset and checks the first-rise timing.
  task automatic do_release();
    mreset = 1'b0;
    for (int e = 0; e < 2; e++) begin
      @(posedge clk);
      #1.25;
      chk(1'b0, "R4");
      @(negedge clk);
      #1.25;
      chk(1'b0, "R4");
    end
    restart = 1;
    step();
    vecs++;
    if (j != 2 || cur != int'(sel) + 3) begin
      fails++;
      $display("FAIL R4: restart slot=%0d expected 2", j);
    end
  endtask

  task automatic hold_reset(input logic [1:0] code);
    mreset = 1'b1;
    sel = code;
    for (int e = 0; e < 2; e++) begin
      @(posedge clk);
      #1.25;
      chk(1'b0, "R3");
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    vecs = 0;
    fails = 0;
    cur = 3;
    j = 0;
    restart = 0;
    chg_mode = 0;
    mreset = 1'b1;
    sel = 2'b00;

    // Each ratio from reset: first-rise timing, then steady periods.
    for (int c = 0; c < 4; c++) begin
      hold_reset(2'(c));
      do_release();
      for (int k = 0; k < 4 * (c + 3); k++) step();
    end

    // Every ordered code pair, with the change at a swept cycle offset.
    for (int a = 0; a < 4; a++) begin
      for (int b = 0; b < 4; b++) begin
        int off;
        int target;
        chg_mode = 0;
        sel = 2'(a);
        for (int k = 0; k < 14; k++) step();
        off = (a * 4 + b) % (a + 3);
        target = 2 * (off + 1);
        step();
        while (j != target) step();
        sel = 2'(b);
        chg_mode = 1;
        for (int k = 0; k < 14; k++) step();
      end
    end
    chg_mode = 0;

    // Asynchronous reset while the output is high, for every ratio.
    for (int c = 0; c < 4; c++) begin
      sel = 2'(c);
      for (int k = 0; k < 8; k++) step();
      while (j != 2 * cur) step();
      @(posedge clk);
      #1.25;
      chk(1'b1, "R1");
      mreset = 1'b1;
      #0.5;
      chk(1'b0, "R3");
      @(negedge clk);
      #1.25;
      chk(1'b0, "R3");
      @(posedge clk);
      #1.25;
      chk(1'b0, "R3");
      do_release();
      for (int k = 0; k < 2 * (c + 3); k++) step();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule